// File: doc/BRIEF.md
# Floating-Point Issue Fault Gate

This block sits in the issue path of a stack-based floating-point unit. For every instruction presented on the issue strobe it decides, in one registered step, whether the instruction may proceed or must fault, and it reports exactly one encoded fault cause when it faults. It owns the unit's control word, status word and tag word, plus the saved data pointer, instruction pointer and last opcode. All six are replaced together when an environment-load instruction is allowed through.

Arithmetic exceptions are deferred. A status flag that is set and not masked does not fault at once. It is reported only when the next waiting-class instruction issues. No-wait instructions are never held back by such a flag. An environment load may install a status word that carries an unmasked flag without faulting itself. The first waiting instruction after it then faults.

Top module: `fpgate`

## Requirements
- R1: After reset, the control word is 16'h037F, the status word is 0, the tag word is 16'hFFFF, both pointers and the last opcode are 0, and `proceed` and `fault` are 0.
- R2: An issued instruction with `ins_lock`=1 faults with cause 1 (undefined opcode). This overrides every other cause.
- R3: An issued instruction with `ins_lock`=0 and `cr0_em`=1 or `cr0_ts`=1 faults with cause 2 (device not available). This overrides a pending exception.
- R4: An issued waiting instruction (`ins_wait`=1) with no lock and both control bits clear faults with cause 3 (math fault) when some status bit i in 0..5 is 1 and control word bit i is 0.
- R5: A no-wait instruction (`ins_wait`=0) with no lock and both control bits clear proceeds even while an unmasked exception is pending.
- R6: `proceed`, `fault` and `fault_cause` show the decision for an issue in the cycle that follows it. In a cycle after no issue, all three are 0. `proceed` and `fault` are never 1 together.
- R7: An environment-load instruction that proceeds writes the control word, status word, tag word, data pointer, instruction pointer and last opcode from the image inputs, all at the same edge.
- R8: `cond_bits` shows the status word's condition bits as {bit 14, bit 10, bit 9, bit 8}. After a load, these bits come straight from the loaded image.
- R9: An environment load whose image holds an unmasked exception does not fault on that account. The next waiting instruction then faults with cause 3.
- R10: An environment-load instruction that faults, for any cause, leaves all six stored fields unchanged.
- R11: A status flag whose control-word mask bit is 1 never produces a math fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_vld | input | 1 | An instruction is presented this cycle |
| ins_wait | input | 1 | 1 = waiting class, 0 = no-wait class |
| ins_lock | input | 1 | Instruction carries a LOCK prefix |
| ins_ldenv | input | 1 | Instruction is an environment load |
| cr0_em | input | 1 | Emulation control bit |
| cr0_ts | input | 1 | Task-switched control bit |
| img_ctrl | input | WORD_W | Control word of the environment image |
| img_stat | input | WORD_W | Status word of the environment image |
| img_tag | input | WORD_W | Tag word of the environment image |
| img_dptr | input | PTR_W | Data pointer of the environment image |
| img_iptr | input | PTR_W | Instruction pointer of the environment image |
| img_opc | input | OPC_W | Last opcode of the environment image |
| proceed | output | 1 | Previous-cycle issue may proceed |
| fault | output | 1 | Previous-cycle issue faults |
| fault_cause | output | 2 | 0 none, 1 undefined opcode, 2 device not available, 3 math fault |
| ctrl_word | output | WORD_W | Stored control word |
| stat_word | output | WORD_W | Stored status word |
| tag_word | output | WORD_W | Stored tag word |
| data_ptr | output | PTR_W | Stored data pointer |
| inst_ptr | output | PTR_W | Stored instruction pointer |
| last_opc | output | OPC_W | Stored last opcode |
| cond_bits | output | 4 | Condition bits C3..C0 of the status word |

## Verification
The decision for an issue and any environment write both land on the edge that follows the issue strobe. Inputs are driven on the falling edge and held for one full cycle. Every output check is made on the next falling edge, exactly one register stage later. A pending exception is always taken from the stored words as they were before the issuing edge. For that reason the bench only expects a freshly loaded status word to matter for the instruction after the load.

// File: rtl/fpgate_pkg.sv
package fpgate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_UD   = 2'd1,
    CAUSE_NM   = 2'd2,
    CAUSE_MF   = 2'd3
  } cause_e;

  // Priority pick: lock beats device-off beats pending math fault.
  function automatic cause_e pick_cause(input logic lock, input logic dev_off,
                                        input logic waiting, input logic pend);
    if (lock)                return CAUSE_UD;
    else if (dev_off)        return CAUSE_NM;
    else if (waiting && pend) return CAUSE_MF;
    else                     return CAUSE_NONE;
  endfunction

  // Condition bits C3..C0 live at status positions 14, 10, 9, 8.
  function automatic logic [3:0] cond_of(input logic [15:0] stat);
    return {stat[14], stat[10], stat[9], stat[8]};
  endfunction

endpackage

// File: rtl/fpgate_cause.sv
module fpgate_cause
  import fpgate_pkg::*;
#(
  parameter int EXC_N = 6
) (
  input  logic [EXC_N-1:0] stat_flags,
  input  logic [EXC_N-1:0] ctrl_masks,
  input  logic             lock,
  input  logic             em,
  input  logic             ts,
  input  logic             waiting,
  output logic             pend,
  output cause_e           cause
);

  logic [EXC_N-1:0] unmasked;

  for (genvar i = 0; i < EXC_N; i++) begin : g_exc
    assign unmasked[i] = stat_flags[i] & ~ctrl_masks[i];
  end

  assign pend  = |unmasked;
  assign cause = pick_cause(lock, em | ts, waiting, pend);

endmodule

// File: rtl/fpgate_env_regs.sv
module fpgate_env_regs #(
  parameter int WORD_W = 16,
  parameter int PTR_W  = 32,
  parameter int OPC_W  = 11,
  parameter logic [WORD_W-1:0] CTRL_RST = 16'h037F,
  parameter logic [WORD_W-1:0] TAG_RST  = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] in_ctrl,
  input  logic [WORD_W-1:0] in_stat,
  input  logic [WORD_W-1:0] in_tag,
  input  logic [PTR_W-1:0]  in_dptr,
  input  logic [PTR_W-1:0]  in_iptr,
  input  logic [OPC_W-1:0]  in_opc,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] stat_q,
  output logic [WORD_W-1:0] tag_q,
  output logic [PTR_W-1:0]  dptr_q,
  output logic [PTR_W-1:0]  iptr_q,
  output logic [OPC_W-1:0]  opc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      stat_q <= '0;
      tag_q  <= TAG_RST;
      dptr_q <= '0;
      iptr_q <= '0;
      opc_q  <= '0;
    end else if (load_en) begin
      ctrl_q <= in_ctrl;
      stat_q <= in_stat;
      tag_q  <= in_tag;
      dptr_q <= in_dptr;
      iptr_q <= in_iptr;
      opc_q  <= in_opc;
    end
  end

endmodule

// File: rtl/fpgate.sv
module fpgate
  import fpgate_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PTR_W  = 32,
  parameter int OPC_W  = 11,
  parameter int EXC_N  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_vld,
  input  logic              ins_wait,
  input  logic              ins_lock,
  input  logic              ins_ldenv,
  input  logic              cr0_em,
  input  logic              cr0_ts,
  input  logic [WORD_W-1:0] img_ctrl,
  input  logic [WORD_W-1:0] img_stat,
  input  logic [WORD_W-1:0] img_tag,
  input  logic [PTR_W-1:0]  img_dptr,
  input  logic [PTR_W-1:0]  img_iptr,
  input  logic [OPC_W-1:0]  img_opc,
  output logic              proceed,
  output logic              fault,
  output logic [1:0]        fault_cause,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] stat_word,
  output logic [WORD_W-1:0] tag_word,
  output logic [PTR_W-1:0]  data_ptr,
  output logic [PTR_W-1:0]  inst_ptr,
  output logic [OPC_W-1:0]  last_opc,
  output logic [3:0]        cond_bits
);

  // Named internal events, observed by the bound checker.
  logic   pend_w;
  cause_e cause_w;
  logic   go_w;
  logic   stop_w;
  logic   load_w;

  fpgate_cause #(.EXC_N(EXC_N)) u_cause (
    .stat_flags (stat_word[EXC_N-1:0]),
    .ctrl_masks (ctrl_word[EXC_N-1:0]),
    .lock       (ins_lock),
    .em         (cr0_em),
    .ts         (cr0_ts),
    .waiting    (ins_wait),
    .pend       (pend_w),
    .cause      (cause_w)
  );

  assign go_w   = issue_vld && (cause_w == CAUSE_NONE);
  assign stop_w = issue_vld && (cause_w != CAUSE_NONE);
  assign load_w = go_w && ins_ldenv;

  fpgate_env_regs #(
    .WORD_W (WORD_W),
    .PTR_W  (PTR_W),
    .OPC_W  (OPC_W)
  ) u_env (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_w),
    .in_ctrl (img_ctrl),
    .in_stat (img_stat),
    .in_tag  (img_tag),
    .in_dptr (img_dptr),
    .in_iptr (img_iptr),
    .in_opc  (img_opc),
    .ctrl_q  (ctrl_word),
    .stat_q  (stat_word),
    .tag_q   (tag_word),
    .dptr_q  (data_ptr),
    .iptr_q  (inst_ptr),
    .opc_q   (last_opc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proceed     <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= CAUSE_NONE;
    end else begin
      proceed     <= go_w;
      fault       <= stop_w;
      fault_cause <= issue_vld ? cause_w : CAUSE_NONE;
    end
  end

  assign cond_bits = cond_of(stat_word[15:0]);

endmodule

// File: rtl/fpgate_chk.sv
module fpgate_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_vld,
  input logic              ins_wait,
  input logic              ins_lock,
  input logic              ins_ldenv,
  input logic              cr0_em,
  input logic              cr0_ts,
  input logic [WORD_W-1:0] img_stat,
  input logic              pend_w,
  input logic              proceed,
  input logic              fault,
  input logic [1:0]        fault_cause,
  input logic [WORD_W-1:0] ctrl_word,
  input logic [WORD_W-1:0] stat_word,
  input logic [WORD_W-1:0] tag_word
);

  // R2
  lock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && ins_lock |=> fault && fault_cause == 2'd1);

  // R3
  devoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && !ins_lock && (cr0_em || cr0_ts) |=> fault && fault_cause == 2'd2);

  // R4
  math_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && ins_wait && !ins_lock && !cr0_em && !cr0_ts && pend_w
      |=> fault && fault_cause == 2'd3);

  // R5
  nowait_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && !ins_wait && !ins_lock && !cr0_em && !cr0_ts |=> proceed && !fault);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> !proceed && !fault && fault_cause == 2'd0);

  // R6
  excl_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({proceed, fault}));

  // R7
  load_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && ins_ldenv |=> (!proceed || stat_word == $past(img_stat)));

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && fault_cause == 2'd0 ##1 fault
      |-> $stable(ctrl_word) && $stable(stat_word) && $stable(tag_word));

endmodule

bind fpgate fpgate_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_vld   (issue_vld),
  .ins_wait    (ins_wait),
  .ins_lock    (ins_lock),
  .ins_ldenv   (ins_ldenv),
  .cr0_em      (cr0_em),
  .cr0_ts      (cr0_ts),
  .img_stat    (img_stat),
  .pend_w      (pend_w),
  .proceed     (proceed),
  .fault       (fault),
  .fault_cause (fault_cause),
  .ctrl_word   (ctrl_word),
  .stat_word   (stat_word),
  .tag_word    (tag_word)
);

// File: tb/test_fpgate.sv
module test_fpgate;

  localparam int WORD_W = 16;
  localparam int PTR_W  = 32;
  localparam int OPC_W  = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              issue_vld = 1'b0, ins_wait = 1'b0, ins_lock = 1'b0, ins_ldenv = 1'b0;
  logic              cr0_em = 1'b0, cr0_ts = 1'b0;
  logic [WORD_W-1:0] img_ctrl = '0, img_stat = '0, img_tag = '0;
  logic [PTR_W-1:0]  img_dptr = '0, img_iptr = '0;
  logic [OPC_W-1:0]  img_opc = '0;
  logic              proceed, fault;
  logic [1:0]        fault_cause;
  logic [WORD_W-1:0] ctrl_word, stat_word, tag_word;
  logic [PTR_W-1:0]  data_ptr, inst_ptr;
  logic [OPC_W-1:0]  last_opc;
  logic [3:0]        cond_bits;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fpgate i_fpgate (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .ins_wait(ins_wait),
    .ins_lock(ins_lock), .ins_ldenv(ins_ldenv), .cr0_em(cr0_em), .cr0_ts(cr0_ts),
    .img_ctrl(img_ctrl), .img_stat(img_stat), .img_tag(img_tag),
    .img_dptr(img_dptr), .img_iptr(img_iptr), .img_opc(img_opc),
    .proceed(proceed), .fault(fault), .fault_cause(fault_cause),
    .ctrl_word(ctrl_word), .stat_word(stat_word), .tag_word(tag_word),
    .data_ptr(data_ptr), .inst_ptr(inst_ptr), .last_opc(last_opc),
    .cond_bits(cond_bits)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one instruction at a falling edge; outputs are read at the next falling edge.
  task automatic issue(input logic w, input logic lk, input logic ld, input logic em, input logic ts);
    @(negedge clk);
    issue_vld = 1'b1; ins_wait = w; ins_lock = lk; ins_ldenv = ld; cr0_em = em; cr0_ts = ts;
    @(negedge clk);
    issue_vld = 1'b0; ins_wait = 1'b0; ins_lock = 1'b0; ins_ldenv = 1'b0; cr0_em = 1'b0; cr0_ts = 1'b0;
  endtask

  function automatic logic [63:0] pack_state();
    return {ctrl_word, stat_word, tag_word, 16'h0} ^ {data_ptr, inst_ptr} ^ 64'(last_opc);
  endfunction

  // No-wait environment load that must go through (R7, R8, R9).
  task automatic load_env(input logic [15:0] c, input logic [15:0] s, input logic [15:0] t,
                          input logic [31:0] dp, input logic [31:0] ip, input logic [10:0] op);
    img_ctrl = c; img_stat = s; img_tag = t; img_dptr = dp; img_iptr = ip; img_opc = op;
    issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R9 load proceeds", {proceed, fault}, 2'b10);
    check("R7 ctrl", ctrl_word, c);
    check("R7 stat", stat_word, s);
    check("R7 tag", tag_word, t);
    check("R7 dptr", data_ptr, dp);
    check("R7 iptr", inst_ptr, ip);
    check("R7 opc", last_opc, op);
    check("R8 cond", cond_bits, {s[14], s[10], s[9], s[8]});
  endtask

  // Sweep every {wait, lock, em, ts} combination against the stored words.
  task automatic sweep(input logic [15:0] c, input logic [15:0] s);
    logic pend;
    pend = ((s & ~c) & 16'h003F) != 16'h0;
    for (int k = 0; k < 16; k++) begin
      logic w, lk, em, ts;
      logic [1:0] exp;
      {w, lk, em, ts} = 4'(k);
      exp = lk ? 2'd1 : ((em | ts) ? 2'd2 : ((w & pend) ? 2'd3 : 2'd0));
      issue(w, lk, 1'b0, em, ts);
      if (lk)            check("R2 lock cause", {proceed, fault, fault_cause}, {2'b01, exp});
      else if (em | ts)  check("R3 devoff cause", {proceed, fault, fault_cause}, {2'b01, exp});
      else if (!w)       check("R5 no-wait pass", {proceed, fault, fault_cause}, {2'b10, exp});
      else if (pend)     check("R4 math fault", {proceed, fault, fault_cause}, {2'b01, exp});
      else               check("R11 masked pass", {proceed, fault, fault_cause}, {2'b10, exp});
    end
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] snap;
    #35 rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl", ctrl_word, 16'h037F);
    check("R1 stat", stat_word, 16'h0);
    check("R1 tag", tag_word, 16'hFFFF);
    check("R1 ptrs", {data_ptr, inst_ptr, 21'(last_opc)}, 85'h0);
    check("R1 resp", {proceed, fault}, 2'b00);
    @(negedge clk);
    check("R6 idle", {proceed, fault, fault_cause}, 4'h0);

    sweep(16'h037F, 16'h0);
    for (int b = 0; b < 6; b++) begin
      logic [15:0] st;
      st = 16'(1 << b) | 16'h4500;
      load_env(16'h037F, st, 16'(16'h1234 + b), 32'(32'hA000 + b), 32'(32'hB000 + b), 11'(b + 5));
      sweep(16'h037F, st);
      load_env(16'h037F & ~16'(1 << b), st, 16'h00F0, 32'h1, 32'h2, 11'h7FF);
      sweep(16'h037F & ~16'(1 << b), st);
      @(negedge clk);
      check("R6 idle after sweep", {proceed, fault, fault_cause}, 4'h0);
    end

    // A pending exception is now stored (mask bit 5 clear, flag 5 set).
    snap = pack_state();
    img_ctrl = 16'h0000; img_stat = 16'h0000; img_tag = 16'h5555;
    img_dptr = 32'hDEAD; img_iptr = 32'hBEEF; img_opc = 11'h123;
    issue(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R10 locked load faults", {fault, fault_cause}, 3'b101);
    check("R10 locked load no write", pack_state(), snap);
    issue(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R10 devoff load faults", {fault, fault_cause}, 3'b110);
    check("R10 devoff load no write", pack_state(), snap);
    issue(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 waiting load math faults", {fault, fault_cause}, 3'b111);
    check("R10 waiting load no write", pack_state(), snap);

    // Clean image loaded by a no-wait load; waiting instructions then pass.
    load_env(16'h0000, 16'h0000, 16'h5555, 32'hDEAD, 32'hBEEF, 11'h123);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 cleared image passes", {proceed, fault}, 2'b10);

    // Image with an unmasked flag loads without faulting; next waiting faults.
    load_env(16'h0000, 16'h4701, 16'h0, 32'h0, 32'h0, 11'h0);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 next waiting faults", {fault, fault_cause}, 3'b111);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule